// File: doc/BRIEF.md
# Receive FIFO with Programmable Level Flags

This block buffers 32-bit words arriving from a high-speed parallel input port and holds them until a local bus reads them out. A small register set controls it. A control register enables reception and carries two self-clearing reset commands. A threshold register sets the almost-empty and almost-full levels. A status register reports four level flags in inverted form, together with two sticky error bits. Two read-only registers give the storage depth and the current fill count. Reading the data address removes the oldest word from the buffer.

A demand request output tells an external transfer engine when words are waiting. A ready output stays low for a programmed settling window after a board reset, so software knows when it may touch the buffer again. Register offsets are in bytes on an 8-bit address: control 0x00, status 0x04, thresholds 0x08, data 0x0C, depth 0x10, word count 0x14. Read data is combinational for the address presented while `bus_sel` is high and `bus_wr` is low, and is zero otherwise. A pop or a register write takes effect at the next rising clock edge.

Top module: `rx_word_fifo`

## Requirements
- R1: A word on `in_data` with `in_valid` high is stored only while control bit 5 (receive enable) is 1. While that bit is 0, incoming words are dropped and the word count does not grow.
- R2: Each read of the data register (0x0C) returns the oldest stored word and removes it, so words come out in the order they arrived.
- R3: Status bit 12 is 1 when the fill count is nonzero. Status bit 15 is 1 when the fill count is below DEPTH. The fill count never exceeds DEPTH.
- R4: Status bit 13 is 1 when the fill count is strictly greater than the almost-empty threshold, which is held in threshold register bits 15:0.
- R5: Status bit 14 is 1 when the fill count plus the almost-full threshold (threshold register bits 31:16) is below DEPTH.
- R6: After reset, the threshold register reads 0x0020_0020, which means 32 words for each threshold. A write to the register replaces both fields.
- R7: An enabled word that arrives while the buffer is full is dropped and sets status bit 23 (overrun). The bit stays set until software writes 1 to bit 23 of the status register.
- R8: A data read while the buffer is empty returns 0 and sets status bit 22 (underrun). Writing 1 to bit 22 of the status register clears it.
- R9: Writing control bit 2 empties the buffer and clears both error bits. It leaves the thresholds unchanged, and the enable bit takes the value written in the same word.
- R10: Writing control bit 0 empties the buffer, clears the enable and error bits, and restores both thresholds to 32. `ready` then stays low for READY_CYCLES clock edges. The same window follows the deassertion of `rst_n`.
- R11: The depth register (0x10) returns DEPTH in bits 19:0. The word-count register (0x14) returns the current fill count in bits 19:0.
- R12: `dma_req` is high exactly when receive is enabled and the buffer holds at least one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | An incoming word is present this cycle |
| in_data | input | DATA_W | Incoming word |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the presented address |
| dma_req | output | 1 | Words are waiting and receive is enabled |
| ready | output | 1 | Settling window after a board reset has expired |

## Verification
The assertions assume that a bus access never writes and reads in the same cycle, since a single `bus_wr` selects the direction. They also assume that inputs are stable around the rising edge. The stimulus changes every input only on the falling edge, and it issues one register access at a time, separated by an idle cycle. Words are pushed only through `in_valid`, and pops happen only through data-register reads. This keeps the model's fill count in step with the number of accepted pushes minus the number of successful pops. The full and empty boundaries are reached on purpose, never as a side effect of overlapping traffic.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int REG_W = 32;

  localparam logic [7:0] OFF_CTRL  = 8'h00;
  localparam logic [7:0] OFF_STAT  = 8'h04;
  localparam logic [7:0] OFF_THR   = 8'h08;
  localparam logic [7:0] OFF_DATA  = 8'h0C;
  localparam logic [7:0] OFF_DEPTH = 8'h10;
  localparam logic [7:0] OFF_WORDS = 8'h14;

  // control bits
  localparam int CB_BOARD_RST = 0;
  localparam int CB_FIFO_RST  = 2;
  localparam int CB_RX_EN     = 5;
  // status bits
  localparam int SB_FLAG_LO = 12;
  localparam int SB_UNR     = 22;
  localparam int SB_OVR     = 23;

  localparam logic [15:0] THR_DEFAULT = 16'd32;

  // inverted level flags, packed so that bit 0 lands on status bit 12
  typedef struct packed {
    logic not_full;
    logic not_afull;
    logic not_aempty;
    logic not_empty;
  } rx_flags_t;

  function automatic logic at_or_below(input logic [31:0] cnt, input logic [15:0] thr);
    return cnt <= {16'd0, thr};
  endfunction

  function automatic logic near_top(input logic [31:0] cnt, input logic [31:0] depth,
                                    input logic [15:0] thr);
    return (cnt + {16'd0, thr}) >= depth;
  endfunction
endpackage

// File: rtl/rxf_storage.sv
module rxf_storage #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head_data,
  output logic [CNT_W-1:0]  fill_cnt,
  output logic              empty,
  output logic              full
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      fill_cnt <= '0;
    end else if (clr) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      fill_cnt <= '0;
    end else begin
      if (push) wr_ptr <= step(wr_ptr);
      if (pop)  rd_ptr <= step(rd_ptr);
      case ({push, pop})
        2'b10:   fill_cnt <= fill_cnt + 1'b1;
        2'b01:   fill_cnt <= fill_cnt - 1'b1;
        default: fill_cnt <= fill_cnt;
      endcase
    end
  end

  assign head_data = mem[rd_ptr];
  assign empty     = (fill_cnt == '0);
  assign full      = (fill_cnt == CNT_W'(DEPTH));
endmodule

// File: rtl/rxf_flags.sv
module rxf_flags
  import rxf_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0] fill_cnt,
  input  logic [15:0]      ae_thr,
  input  logic [15:0]      af_thr,
  output rx_flags_t        flags
);
  logic [31:0] cnt32;
  assign cnt32 = 32'(fill_cnt);

  always_comb begin
    flags.not_empty  = (cnt32 != 32'd0);
    flags.not_aempty = !at_or_below(cnt32, ae_thr);
    flags.not_afull  = !near_top(cnt32, 32'(DEPTH), af_thr);
    flags.not_full   = (cnt32 != 32'(DEPTH));
  end
endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
  import rxf_pkg::*;
#(
  parameter int READY_CYCLES = 500,
  localparam int RDY_W = $clog2(READY_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic             stat_wr,
  input  logic             thr_wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             overrun_ev,
  input  logic             underrun_ev,
  output logic             board_rst,
  output logic             fifo_clr,
  output logic             rx_en,
  output logic [15:0]      ae_thr,
  output logic [15:0]      af_thr,
  output logic             ovr_flag,
  output logic             unr_flag,
  output logic             ready
);
  localparam logic [RDY_W-1:0] RDY_LOAD = RDY_W'(READY_CYCLES);

  logic [RDY_W-1:0] rdy_cnt;

  assign board_rst = ctrl_wr && wdata[CB_BOARD_RST];
  assign fifo_clr  = board_rst || (ctrl_wr && wdata[CB_FIFO_RST]);
  assign ready     = (rdy_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en    <= 1'b0;
      ae_thr   <= THR_DEFAULT;
      af_thr   <= THR_DEFAULT;
      ovr_flag <= 1'b0;
      unr_flag <= 1'b0;
      rdy_cnt  <= RDY_LOAD;
    end else begin
      if (board_rst)    rx_en <= 1'b0;
      else if (ctrl_wr) rx_en <= wdata[CB_RX_EN];

      if (board_rst) begin
        ae_thr <= THR_DEFAULT;
        af_thr <= THR_DEFAULT;
      end else if (thr_wr) begin
        ae_thr <= wdata[15:0];
        af_thr <= wdata[31:16];
      end

      if (fifo_clr)                        ovr_flag <= 1'b0;
      else if (overrun_ev)                 ovr_flag <= 1'b1;
      else if (stat_wr && wdata[SB_OVR])   ovr_flag <= 1'b0;

      if (fifo_clr)                        unr_flag <= 1'b0;
      else if (underrun_ev)                unr_flag <= 1'b1;
      else if (stat_wr && wdata[SB_UNR])   unr_flag <= 1'b0;

      if (board_rst)          rdy_cnt <= RDY_LOAD;
      else if (rdy_cnt != '0) rdy_cnt <= rdy_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/rx_word_fifo.sv
module rx_word_fifo
  import rxf_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int DEPTH        = 64,
  parameter int READY_CYCLES = 500,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [7:0]        bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              dma_req,
  output logic              ready
);
  // named internal events, also watched by the bound checker
  logic              ctrl_wr, stat_wr, thr_wr, pop_req, push_req;
  logic              push_ok, pop_ok, overrun_ev, underrun_ev;
  logic              board_rst, fifo_clr, rx_en, ovr_flag, unr_flag;
  logic              empty, full;
  logic [CNT_W-1:0]  fill_cnt;
  logic [DATA_W-1:0] head_data;
  logic [15:0]       ae_thr, af_thr;
  rx_flags_t         flags;

  assign ctrl_wr  = bus_sel && bus_wr && (bus_addr == OFF_CTRL);
  assign stat_wr  = bus_sel && bus_wr && (bus_addr == OFF_STAT);
  assign thr_wr   = bus_sel && bus_wr && (bus_addr == OFF_THR);
  assign pop_req  = bus_sel && !bus_wr && (bus_addr == OFF_DATA);
  assign push_req = in_valid && rx_en;

  assign push_ok     = push_req && !full  && !fifo_clr;
  assign overrun_ev  = push_req &&  full  && !fifo_clr;
  assign pop_ok      = pop_req  && !empty && !fifo_clr;
  assign underrun_ev = pop_req  &&  empty && !fifo_clr;

  rxf_ctrl #(.READY_CYCLES(READY_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .stat_wr(stat_wr), .thr_wr(thr_wr),
    .wdata(bus_wdata), .overrun_ev(overrun_ev), .underrun_ev(underrun_ev),
    .board_rst(board_rst), .fifo_clr(fifo_clr), .rx_en(rx_en),
    .ae_thr(ae_thr), .af_thr(af_thr), .ovr_flag(ovr_flag), .unr_flag(unr_flag),
    .ready(ready)
  );

  rxf_storage #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .push(push_ok), .push_data(in_data),
    .pop(pop_ok), .head_data(head_data), .fill_cnt(fill_cnt), .empty(empty), .full(full)
  );

  rxf_flags #(.DEPTH(DEPTH)) u_flags (
    .fill_cnt(fill_cnt), .ae_thr(ae_thr), .af_thr(af_thr), .flags(flags)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        OFF_CTRL:  bus_rdata[CB_RX_EN] = rx_en;
        OFF_STAT: begin
          bus_rdata[SB_FLAG_LO +: 4] = flags;
          bus_rdata[SB_UNR]          = unr_flag;
          bus_rdata[SB_OVR]          = ovr_flag;
        end
        OFF_THR:   bus_rdata = {af_thr, ae_thr};
        OFF_DATA:  bus_rdata = empty ? '0 : REG_W'(head_data);
        OFF_DEPTH: bus_rdata[19:0] = 20'(DEPTH);
        OFF_WORDS: bus_rdata[19:0] = 20'(fill_cnt);
        default:   bus_rdata = '0;
      endcase
    end
  end

  assign dma_req = rx_en && !empty;
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_en,
  input logic             push_ok,
  input logic             pop_ok,
  input logic             overrun_ev,
  input logic             underrun_ev,
  input logic [CNT_W-1:0] fill_cnt,
  input logic             ovr_flag,
  input logic             unr_flag,
  input logic             fifo_clr,
  input logic             board_rst,
  input logic             ready,
  input logic             dma_req
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  assert_disabled_no_growth_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> fill_cnt <= $past(fill_cnt));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt <= DEPTH_C);

  assert_pop_shrinks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && !push_ok && !fifo_clr) |=> fill_cnt == $past(fill_cnt) - 1'b1);

  assert_full_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_cnt == DEPTH_C) |-> !push_ok);

  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_ev |=> ovr_flag);

  assert_underrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_ev |=> unr_flag);

  assert_fifo_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (fill_cnt == '0) && !ovr_flag && !unr_flag);

  assert_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    board_rst |=> !ready && !rx_en);

  assert_dma_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> rx_en && (fill_cnt != '0));
endmodule

bind rx_word_fifo rxf_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_rxf_checker (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .push_ok(push_ok), .pop_ok(pop_ok),
  .overrun_ev(overrun_ev), .underrun_ev(underrun_ev), .fill_cnt(fill_cnt),
  .ovr_flag(ovr_flag), .unr_flag(unr_flag), .fifo_clr(fifo_clr),
  .board_rst(board_rst), .ready(ready), .dma_req(dma_req)
);

// File: tb/test_rx_word_fifo.sv
module test_rx_word_fifo;
  localparam int DEPTH = 64;
  localparam int RDY   = 500;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        dma_req, ready;

  int total = 0, bad = 0;
  bit model_en = 0;
  logic [31:0] exp_q[$];
  logic [31:0] rv;

  always #10 clk = ~clk;

  rx_word_fifo #(.DATA_W(32), .DEPTH(DEPTH), .READY_CYCLES(RDY)) i_rx_word_fifo (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .dma_req(dma_req), .ready(ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  // driver: pushes the expected word into the scoreboard when it should be kept
  task automatic push_word(input logic [31:0] d);
    @(negedge clk); in_valid = 1; in_data = d;
    @(negedge clk); in_valid = 0;
    if (model_en && exp_q.size() < DEPTH) exp_q.push_back(d);
  endtask

  // monitor: pops a word out of the design and compares with the scoreboard
  task automatic pop_cmp(input string req);
    logic [31:0] got, want;
    rd(8'h0C, got);
    want = (exp_q.size() == 0) ? 32'h0 : exp_q.pop_front();
    chk(req, got, want);
  endtask

  task automatic chk_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1 chk("R10 ready low after reset", {31'd0, ready}, 32'd0);
    repeat (RDY + 2) @(posedge clk);
    #1 chk("R10 ready after window", {31'd0, ready}, 32'd1);
    chk("R12 dma_req idle", {31'd0, dma_req}, 32'd0);
    chk_reg("R3 reset status", 8'h04, 32'h0000_C000);
    chk_reg("R6 default thresholds", 8'h08, 32'h0020_0020);
    chk_reg("R11 depth", 8'h10, 32'(DEPTH));
    chk_reg("R11 empty count", 8'h14, 32'd0);

    for (int i = 0; i < 3; i++) push_word(32'hDEAD_0000 + i);
    chk_reg("R1 disabled drops words", 8'h14, 32'd0);

    wr(8'h00, 32'h20); model_en = 1;
    chk_reg("R1 enable readback", 8'h00, 32'h20);
    for (int i = 0; i < 5; i++) push_word(32'hA500_0000 + i);
    chk_reg("R11 count five", 8'h14, 32'd5);
    #1 chk("R12 dma_req with words", {31'd0, dma_req}, 32'd1);

    wr(8'h08, 32'h0002_0004);
    chk_reg("R6 threshold write", 8'h08, 32'h0002_0004);
    chk_reg("R4 above almost-empty", 8'h04, 32'h0000_F000);
    pop_cmp("R2 first word");
    pop_cmp("R2 second word");
    chk_reg("R4 at almost-empty", 8'h04, 32'h0000_D000);

    for (int i = 0; i < 59; i++) push_word(32'h5A00_0000 + i);
    chk_reg("R5 almost-full reached", 8'h04, 32'h0000_B000);
    push_word(32'h5B00_0001);
    push_word(32'h5B00_0002);
    chk_reg("R3 full", 8'h04, 32'h0000_3000);
    push_word(32'hBAD0_0001);
    chk_reg("R7 overrun set", 8'h04, 32'h0080_3000);
    chk_reg("R7 count held", 8'h14, 32'(DEPTH));
    wr(8'h04, 32'h0080_0000);
    chk_reg("R7 overrun cleared", 8'h04, 32'h0000_3000);

    for (int i = 0; i < DEPTH; i++) pop_cmp("R2 drain order");
    #1 chk("R12 dma_req empty", {31'd0, dma_req}, 32'd0);
    rd(8'h0C, rv);
    chk("R8 empty read data", rv, 32'd0);
    chk_reg("R8 underrun set", 8'h04, 32'h0040_C000);
    wr(8'h04, 32'h0040_0000);
    chk_reg("R8 underrun cleared", 8'h04, 32'h0000_C000);

    push_word(32'hC000_0001);
    push_word(32'hC000_0002);
    wr(8'h00, 32'h0); model_en = 0;
    #1 chk("R12 dma_req disabled", {31'd0, dma_req}, 32'd0);
    chk_reg("R1 words kept while disabled", 8'h14, 32'd2);
    pop_cmp("R2 pop while disabled");
    pop_cmp("R2 pop while disabled");
    rd(8'h0C, rv);
    wr(8'h00, 32'h20); model_en = 1;
    push_word(32'hC100_0001);
    push_word(32'hC100_0002);
    wr(8'h00, 32'h24);
    exp_q.delete();
    chk_reg("R9 fifo reset status", 8'h04, 32'h0000_C000);
    chk_reg("R9 fifo reset count", 8'h14, 32'd0);
    chk_reg("R9 thresholds kept", 8'h08, 32'h0002_0004);
    push_word(32'hC200_0001);
    chk_reg("R9 enable kept", 8'h14, 32'd1);

    wr(8'h00, 32'h21); model_en = 0; exp_q.delete();
    #1 chk("R10 not ready after board reset", {31'd0, ready}, 32'd0);
    repeat (RDY - 5) @(posedge clk);
    #1 chk("R10 still not ready", {31'd0, ready}, 32'd0);
    chk_reg("R10 count cleared", 8'h14, 32'd0);
    chk_reg("R10 thresholds restored", 8'h08, 32'h0020_0020);
    chk_reg("R10 enable cleared", 8'h00, 32'd0);
    repeat (4) @(posedge clk);
    #1 chk("R10 ready again", {31'd0, ready}, 32'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule